// File: doc/BRIEF.md
# Multiframe Phase Counter with SYSREF Realignment

This block keeps the local multiframe phase of a multi-lane serial receiver. A counter in the link clock domain steps once per cycle and wraps after a configurable number of counts. A rising SYSREF event realigns it, so that the counter passes through zero a fixed two link clock cycles after the edge that first samples SYSREF high. Between events the counter runs freely. The lane logic uses its outputs to time elastic buffer release and link start-up.

Besides the phase value, the block gives three timing signals. The first is a boundary flag, high while the phase is zero. The second is a release strobe, placed a programmable number of counts ahead of the next boundary. This lets the buffer release point move earlier in the multiframe, so that it always lands in the same multiframe from one power cycle to the next. The third is an active-low synchronisation request. It is dropped only as a new multiframe begins, and never in the middle of one.

Top module: `mframe_phase_gen`

## Requirements
- R1: While `rst_ni` is low, `phase_o` reads 0, `mf_edge_o` is high and `sync_req_no` is high.
- R2: With no realignment pending, `phase_o` steps by one on every clock edge and wraps from MF_LEN-1 to 0.
- R3: If `sysref_i` is sampled high at edge E after being sampled low at edge E-1, `phase_o` reads MF_LEN-1 after edge E+1 and reads 0 after edge E+2. It then runs freely again.
- R4: If `sysref_i` stays high for several cycles, only its first high sample realigns the counter. The later high samples leave the free-running count alone.
- R5: `mf_edge_o` is high exactly in the cycles where `phase_o` is 0.
- R6: For an offset value N on `rel_ofs_i` with 1 <= N <= MF_LEN-1, `release_o` is high exactly in the cycles where `phase_o` equals MF_LEN-N. For example, with MF_LEN=8 and N=5 it is high at phase 3.
- R7: An offset value of 0 puts `release_o` on the boundary itself, at phase 0.
- R8: An offset value of MF_LEN or more is treated as MF_LEN-1. `release_o` is then high at phase 1.
- R9: While `link_start_i` is high, `sync_req_no` goes low on the clock edge that brings `phase_o` to 0. Its first low cycle therefore has phase 0. It stays low for as long as `link_start_i` stays high.
- R10: After a clock edge at which `link_start_i` was low, `sync_req_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sysref_i | input | 1 | SYSREF level, sampled in the link clock domain |
| link_start_i | input | 1 | Requests link start; releases the sync request at the next boundary |
| rel_ofs_i | input | CNT_W | Release offset, in counts before the next boundary |
| phase_o | output | CNT_W | Current multiframe phase, 0 to MF_LEN-1 |
| mf_edge_o | output | 1 | High while the phase is 0 |
| release_o | output | 1 | Buffer release strobe |
| sync_req_no | output | 1 | Synchronisation request, active low |

## Verification
The bench builds two copies of the block from the same stimulus. With MF_LEN=8 the wrap comes from natural overflow of the counter, and every offset from 0 to 7 is in range; this includes the offset-5-to-phase-3 case. With MF_LEN=5 the wrap is built from a compare, and the 3-bit offset port can carry 5, 6 and 7, which brings the clamp into reach. Both copies take SYSREF pulses and long SYSREF levels at arbitrary phases, including pulses that arrive while an earlier realignment is still pending.

// File: rtl/mfp_pkg.sv
package mfp_pkg;

   // How the counter wraps, chosen from the multiframe length
   typedef enum logic [0:0] {
      WRAP_NATURAL = 1'b0,
      WRAP_COMPARE = 1'b1
   } wrap_kind_e;

   function automatic wrap_kind_e mf_wrap_kind(int unsigned len);
      return ((len & (len - 1)) == 0) ? WRAP_NATURAL : WRAP_COMPARE;
   endfunction

   // Phase at which the release strobe fires for an offset request
   function automatic int unsigned mf_release_at(int unsigned ofs, int unsigned len);
      int unsigned n;
      n = (ofs >= len) ? len - 1 : ofs;
      return (n == 0) ? 0 : len - n;
   endfunction

endpackage

// File: rtl/mfp_sysref_det.sv
module mfp_sysref_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sysref_i,
   output logic load_o
);
   logic smp_q;
   logic smp_prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         smp_q      <= 1'b0;
         smp_prev_q <= 1'b0;
      end else begin
         smp_q      <= sysref_i;
         smp_prev_q <= smp_q;
      end
   end

   // one-cycle request on the first high sample
   assign load_o = smp_q & ~smp_prev_q;
endmodule

// File: rtl/mfp_phase_cnt.sv
module mfp_phase_cnt #(
   parameter int unsigned MF_LEN = 8,
   parameter int unsigned CNT_W  = $clog2(MF_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   output logic [CNT_W-1:0] phase_o,
   output logic             nxt_zero_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] cnt_d;

   generate
      if (mfp_pkg::mf_wrap_kind(MF_LEN) == mfp_pkg::WRAP_NATURAL) begin : g_wrap_pow2
         assign step = cnt_q + 1'b1;
      end else begin : g_wrap_cmp
         assign step = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   // realignment parks at the last count so zero follows one edge later
   assign cnt_d = load_i ? LAST : step;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign phase_o    = cnt_q;
   assign nxt_zero_o = (cnt_d == '0);
endmodule

// File: rtl/mfp_release_dec.sv
module mfp_release_dec #(
   parameter int unsigned MF_LEN = 8,
   parameter int unsigned CNT_W  = $clog2(MF_LEN)
) (
   input  logic [CNT_W-1:0] phase_i,
   input  logic [CNT_W-1:0] ofs_i,
   output logic             release_o,
   output logic             edge_o
);
   logic [CNT_W-1:0] rel_pos;

   always_comb begin
      rel_pos = CNT_W'(mfp_pkg::mf_release_at(32'(ofs_i), MF_LEN));
   end

   assign release_o = (phase_i == rel_pos);
   assign edge_o    = (phase_i == '0);
endmodule

// File: rtl/mfp_sync_ctrl.sv
module mfp_sync_ctrl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic link_start_i,
   input  logic nxt_zero_i,
   output logic sync_n_o
);
   logic sync_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           sync_q <= 1'b1;
      else if (!link_start_i) sync_q <= 1'b1;
      else if (nxt_zero_i)   sync_q <= 1'b0;
   end

   assign sync_n_o = sync_q;
endmodule

// File: rtl/mframe_phase_gen.sv
module mframe_phase_gen #(
   parameter int unsigned MF_LEN = 8,
   localparam int unsigned CNT_W = (MF_LEN < 2) ? 1 : $clog2(MF_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sysref_i,
   input  logic             link_start_i,
   input  logic [CNT_W-1:0] rel_ofs_i,
   output logic [CNT_W-1:0] phase_o,
   output logic             mf_edge_o,
   output logic             release_o,
   output logic             sync_req_no
);
   generate
      if (MF_LEN < 2) begin : g_bad_len
         $error("mframe_phase_gen: MF_LEN must be at least 2");
      end
   endgenerate

   logic sr_load;
   logic nxt_zero;

   mfp_sysref_det u_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sysref_i (sysref_i),
      .load_o   (sr_load)
   );

   mfp_phase_cnt #(.MF_LEN(MF_LEN), .CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (sr_load),
      .phase_o    (phase_o),
      .nxt_zero_o (nxt_zero)
   );

   mfp_release_dec #(.MF_LEN(MF_LEN), .CNT_W(CNT_W)) u_dec (
      .phase_i   (phase_o),
      .ofs_i     (rel_ofs_i),
      .release_o (release_o),
      .edge_o    (mf_edge_o)
   );

   mfp_sync_ctrl u_sync (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .link_start_i (link_start_i),
      .nxt_zero_i   (nxt_zero),
      .sync_n_o     (sync_req_no)
   );
endmodule

// File: rtl/mframe_phase_gen_chk.sv
module mframe_phase_gen_chk #(
   parameter int unsigned MF_LEN = 8,
   parameter int unsigned CNT_W  = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sysref_i,
   input logic             link_start_i,
   input logic [CNT_W-1:0] rel_ofs_i,
   input logic [CNT_W-1:0] phase_o,
   input logic             mf_edge_o,
   input logic             release_o,
   input logic             sync_req_no,
   input logic             load
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

   // R1
   reset_state_chk: assert property (@(posedge clk_i)
      !rst_ni |-> (phase_o == '0 && sync_req_no));

   // R2
   step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load && phase_o != LAST) |=> phase_o == $past(phase_o) + 1'b1);

   // R2
   wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load && phase_o == LAST) |=> phase_o == '0);

   // R3
   realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load |=> phase_o == LAST);

   // R3
   load_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load |-> $past(sysref_i));

   // R4
   single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load |=> !load);

   // R5
   edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mf_edge_o |=> !mf_edge_o);

   // R6
   release_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (release_o && !load) |=> (!release_o || !$stable(rel_ofs_i)));

   // R9
   sync_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sync_req_no) |-> mf_edge_o);

   // R10
   sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !link_start_i |=> sync_req_no);
endmodule

bind mframe_phase_gen mframe_phase_gen_chk #(.MF_LEN(MF_LEN), .CNT_W(CNT_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .sysref_i     (sysref_i),
   .link_start_i (link_start_i),
   .rel_ofs_i    (rel_ofs_i),
   .phase_o      (phase_o),
   .mf_edge_o    (mf_edge_o),
   .release_o    (release_o),
   .sync_req_no  (sync_req_no),
   .load         (sr_load)
);

// File: tb/mframe_phase_gen_tb.sv
`timescale 1ns/1ps
module mframe_phase_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       sysref = 1'b0;
   logic       lstart = 1'b0;
   logic [2:0] ofs = 3'd0;

   logic [2:0] ph_a, ph_b;
   logic       edge_a, edge_b, rel_a, rel_b, sync_a, sync_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // model state, index 0: MF_LEN=8, index 1: MF_LEN=5
   int  m_len [2] = '{8, 5};
   int  m_ph  [2];
   int  m_cd  [2];
   bit  m_sync[2];
   bit  m_rec [2];
   bit  m_prev;
   bit  held_mode = 1'b0;

   always #2.5 clk = ~clk;

   mframe_phase_gen #(.MF_LEN(8)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .sysref_i(sysref), .link_start_i(lstart),
      .rel_ofs_i(ofs), .phase_o(ph_a), .mf_edge_o(edge_a), .release_o(rel_a),
      .sync_req_no(sync_a));

   mframe_phase_gen #(.MF_LEN(5)) u_dut_odd (
      .clk_i(clk), .rst_ni(rst_n), .sysref_i(sysref), .link_start_i(lstart),
      .rel_ofs_i(ofs), .phase_o(ph_b), .mf_edge_o(edge_b), .release_o(rel_b),
      .sync_req_no(sync_b));

   function automatic int exp_rel_pos(int o, int len);
      int n;
      n = (o >= len) ? len - 1 : o;
      return (n == 0) ? 0 : len - n;
   endfunction

   function automatic string rel_tag(int o, int len);
      if (o == 0)   return "R7";
      if (o >= len) return "R8";
      return "R6";
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         m_ph[i] = 0; m_cd[i] = 0; m_sync[i] = 1'b1; m_rec[i] = 1'b0;
      end
      m_prev = 1'b0;
   endtask

   task automatic compare_all();
      int  ph  [2];
      bit  ed  [2];
      bit  rl  [2];
      bit  sy  [2];
      ph[0] = int'(ph_a); ph[1] = int'(ph_b);
      ed[0] = edge_a;     ed[1] = edge_b;
      rl[0] = rel_a;      rl[1] = rel_b;
      sy[0] = sync_a;     sy[1] = sync_b;
      for (int i = 0; i < 2; i++) begin
         string ptag;
         int    pos;
         ptag = m_rec[i] ? "R3" : (held_mode ? "R4" : "R2");
         chk(ph[i] == m_ph[i], ptag, "phase", ph[i], m_ph[i]);
         chk(ed[i] == (m_ph[i] == 0), "R5", "edge", int'(ed[i]), int'(m_ph[i] == 0));
         pos = exp_rel_pos(int'(ofs), m_len[i]);
         chk(rl[i] == (m_ph[i] == pos), rel_tag(int'(ofs), m_len[i]), "release",
             int'(rl[i]), int'(m_ph[i] == pos));
         chk(sy[i] == m_sync[i], lstart ? "R9" : "R10", "sync", int'(sy[i]), int'(m_sync[i]));
      end
   endtask

   // one clock: inputs already set at a falling edge
   task automatic cycle();
      bit rise;
      @(posedge clk);
      rise   = sysref && !m_prev;
      m_prev = sysref;
      for (int i = 0; i < 2; i++) begin
         m_rec[i] = (m_cd[i] > 0);
         if (m_cd[i] == 2) m_ph[i] = m_len[i] - 1;
         else              m_ph[i] = (m_ph[i] + 1) % m_len[i];
         if (m_cd[i] > 0) m_cd[i]--;
         if (rise) m_cd[i] = 2;
         if (!lstart)           m_sync[i] = 1'b1;
         else if (m_ph[i] == 0) m_sync[i] = 1'b0;
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) cycle();
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      model_reset();
      // R1 reset state
      chk(ph_a == 3'd0 && ph_b == 3'd0, "R1", "reset phase", int'(ph_a) + int'(ph_b), 0);
      chk(sync_a && sync_b, "R1", "reset sync", int'(sync_a & sync_b), 1);
      chk(edge_a && edge_b, "R1", "reset edge", int'(edge_a & edge_b), 1);
      rst_n = 1'b1;

      // R2 free run, R6 offset 5 -> phase 3 on the 8-count copy
      ofs = 3'd5;
      run(12);
      // R3 single pulse
      sysref = 1'b1; cycle(); sysref = 1'b0;
      run(10);
      // R4 long level
      held_mode = 1'b1;
      sysref = 1'b1; run(20); sysref = 1'b0;
      run(6);
      held_mode = 1'b0;
      // R7 offset zero
      ofs = 3'd0; run(10);
      // R8 clamp on the 5-count copy
      ofs = 3'd7; run(10);
      ofs = 3'd5; run(6);
      // R9 start, R10 stop
      lstart = 1'b1; run(20);
      lstart = 1'b0; run(4);
      // back-to-back pulses while a realignment is pending
      sysref = 1'b1; cycle(); sysref = 1'b0; cycle();
      sysref = 1'b1; cycle(); sysref = 1'b0; run(8);

      // constrained random
      begin
         int hold = 0;
         for (int k = 0; k < 3000; k++) begin
            if (hold > 0) begin
               hold--;
               if (hold == 0) sysref = 1'b0;
            end else if ($urandom_range(39) == 0) begin
               sysref = 1'b1;
               hold   = $urandom_range(6, 1);
            end
            if ($urandom_range(29) == 0) ofs = 3'($urandom_range(7));
            if ($urandom_range(99) == 0) lstart = ~lstart;
            cycle();
         end
      end
      sysref = 1'b0;
      run(4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule